// File: doc/BRIEF.md
# Type-Interpreted Shared Predictor Table

This block is one small tagged prediction table that serves three kinds of speculation at once. A lookup brings an instruction address and a 2-bit instruction kind. The table index and tag are hashed from the address and the global branch history. Each tagged entry carries one 3-bit field, and the kind of the lookup decides what that field means. For a conditional branch it is a saturating direction counter. For a load it is the number of older stores back that the load should wait for. For an indirect branch it selects a slot of an eight-entry target buffer, and the target held in that slot is the prediction.

When the tagged table misses, a conditional branch falls back to a base table of direction counters indexed by the address alone. A load or an indirect branch that misses gets no prediction. Resolution updates from execute train the base counters, step or rewrite tagged entries, and fill target-buffer slots in round-robin order. A branch misprediction also restores the global history from the checkpoint carried by the update. Every lookup answers one cycle later with a valid flag and a flag that tells whether the tagged table supplied the answer.

Top module: `osp_shared_pred`

## Requirements
- R1: `rsp_ack` is high in the cycle after each cycle with `lk_valid` high and low otherwise, including after reset.
- R2: Kind codes are 00 conditional branch, 01 load, 10 indirect branch, 11 none. A kind-11 lookup answers with `rsp_valid`, `rsp_tagged`, `rsp_taken`, `rsp_dist` and `rsp_target` all zero.
- R3: The tagged index is `pc[5:0] XOR ghr[5:0]`. The tag is `pc[13:6] XOR {6'b0, ghr[7:6]}`. A hit needs a valid entry with an equal tag. The base index is `pc[5:0]`.
- R4: A conditional lookup is always valid. It predicts taken when the 3-bit value is 4 or more, using the tagged field on a hit and otherwise the base counter. `rsp_tagged` shows which table was used. Base counters reset to 3. `rsp_dist` and `rsp_target` are zero.
- R5: A load lookup that hits returns `rsp_valid`=1, `rsp_tagged`=1 and `rsp_dist` equal to the field, where 0 means no dependency. A miss returns all zero.
- R6: An indirect lookup that hits returns `rsp_valid`=1, `rsp_tagged`=1 and `rsp_target` equal to the target-buffer slot named by the field. A miss returns all zero.
- R7: A resolved conditional update always steps its base counter toward `up_taken`, saturating at 0 and 7. If `up_wrong` is set, it writes the tagged entry with the new tag and a field of 4 if taken or 3 if not. Otherwise, on a tagged hit, it steps the field toward `up_taken`, saturating.
- R8: A load update with `up_wrong` (a memory-order violation) writes the tagged entry with the field `min(up_dist, 7)`.
- R9: An indirect update with `up_wrong` writes `up_target` into the round-robin slot and writes that slot number as the entry field. The slot starts at 0 after reset and advances by 1 modulo 8 on each such update.
- R10: A conditional lookup shifts its predicted direction into the history at bit 0. `rsp_ghr` returns the history that the lookup used, and is zero when no lookup was made.
- R11: A conditional update with `up_wrong` loads the history with `{up_ghr[6:0], up_taken}`. This takes precedence over a shift in the same cycle.
- R12: An answer reflects the table, counters, buffer and history as they stood before the clock edge that accepts the lookup. An update in the same cycle is visible only to later lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | 14 | Lookup instruction address |
| lk_kind | input | 2 | Lookup instruction kind |
| up_valid | input | 1 | Resolution update present |
| up_pc | input | 14 | Update instruction address |
| up_kind | input | 2 | Update instruction kind |
| up_ghr | input | 8 | History checkpoint taken at lookup |
| up_wrong | input | 1 | Mispredict or memory-order violation |
| up_taken | input | 1 | Resolved branch direction |
| up_dist | input | 4 | Observed store distance |
| up_target | input | 16 | Resolved indirect target |
| rsp_ack | output | 1 | Answer present |
| rsp_valid | output | 1 | Prediction valid |
| rsp_tagged | output | 1 | Answer came from the tagged table |
| rsp_taken | output | 1 | Predicted direction |
| rsp_dist | output | 3 | Predicted store distance |
| rsp_target | output | 16 | Predicted indirect target |
| rsp_ghr | output | 8 | History used by the lookup |

## Verification
The hardest situation to reach from the ports is a tagged hit. The allocating update and a later lookup must hash the same address under the same history, but every conditional lookup moves the history in between. Directed steps reach the hit in two ways. Some updates carry the live history as their checkpoint while no conditional lookup intervenes. One restore is chosen with a checkpoint of all ones, so the restored history still hashes to the entry it just allocated. The random phase draws addresses from a small pool and mostly reuses the live history, so hits, overwrites, same-cycle lookup and update collisions and target-buffer wrap-around all recur.

// File: rtl/osp_pkg.sv
package osp_pkg;
  localparam int FLD_W = 3;
  localparam int TB_DEPTH = 1 << FLD_W;

  typedef enum logic [1:0] {
    KIND_COND = 2'b00,
    KIND_LOAD = 2'b01,
    KIND_IND  = 2'b10,
    KIND_NONE = 2'b11
  } kind_e;

  function automatic logic [FLD_W-1:0] sat_step(input logic [FLD_W-1:0] v, input logic up);
    logic [FLD_W-1:0] r;
    r = v;
    if (up && v != {FLD_W{1'b1}}) r = v + 1'b1;
    else if (!up && v != '0) r = v - 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/osp_ghr.sv
module osp_ghr #(
  parameter int GHR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             shift_bit,
  input  logic             restore_en,
  input  logic [GHR_W-1:0] restore_val,
  output logic [GHR_W-1:0] hist_q
);
  always_ff @(posedge clk) begin
    if (rst) hist_q <= '0;
    else if (restore_en) hist_q <= restore_val;
    else if (shift_en) hist_q <= {hist_q[GHR_W-2:0], shift_bit};
  end
endmodule

// File: rtl/osp_base.sv
module osp_base #(
  parameter int AW = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [AW-1:0]             rd_idx,
  output logic [osp_pkg::FLD_W-1:0] rd_ctr,
  input  logic                      up_en,
  input  logic [AW-1:0]             up_idx,
  input  logic                      up_dir
);
  import osp_pkg::*;
  localparam int DEPTH = 1 << AW;
  localparam logic [FLD_W-1:0] CTR_INIT = 3'd3;

  logic [FLD_W-1:0] ctr_q [DEPTH];

  assign rd_ctr = ctr_q[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_INIT;
    end else if (up_en) begin
      ctr_q[up_idx] <= sat_step(ctr_q[up_idx], up_dir);
    end
  end
endmodule

// File: rtl/osp_tagtab.sv
module osp_tagtab #(
  parameter int AW    = 6,
  parameter int TAG_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [AW-1:0]             rd_idx,
  output logic                      rd_val,
  output logic [TAG_W-1:0]          rd_tag,
  output logic [osp_pkg::FLD_W-1:0] rd_fld,
  input  logic [AW-1:0]             up_idx,
  output logic                      up_val,
  output logic [TAG_W-1:0]          up_tag,
  output logic [osp_pkg::FLD_W-1:0] up_fld,
  input  logic                      wr_en,
  input  logic [TAG_W-1:0]          wr_tag,
  input  logic [osp_pkg::FLD_W-1:0] wr_fld
);
  import osp_pkg::*;
  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0] vld_q;
  logic [TAG_W-1:0] tag_m [DEPTH];
  logic [FLD_W-1:0] fld_m [DEPTH];

  assign rd_val = vld_q[rd_idx];
  assign rd_tag = tag_m[rd_idx];
  assign rd_fld = fld_m[rd_idx];
  assign up_val = vld_q[up_idx];
  assign up_tag = tag_m[up_idx];
  assign up_fld = fld_m[up_idx];

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else if (wr_en) vld_q[up_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_m[up_idx] <= wr_tag;
      fld_m[up_idx] <= wr_fld;
    end
  end
endmodule

// File: rtl/osp_tbuf.sv
module osp_tbuf #(
  parameter int TGT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [osp_pkg::FLD_W-1:0] rd_slot,
  output logic [TGT_W-1:0]          rd_tgt,
  input  logic                      wr_en,
  input  logic [TGT_W-1:0]          wr_tgt,
  output logic [osp_pkg::FLD_W-1:0] alloc_slot
);
  import osp_pkg::*;

  logic [TGT_W-1:0] tgt_q [TB_DEPTH];

  assign rd_tgt = tgt_q[rd_slot];

  always_ff @(posedge clk) begin
    if (rst) begin
      alloc_slot <= '0;
      for (int i = 0; i < TB_DEPTH; i++) tgt_q[i] <= '0;
    end else if (wr_en) begin
      tgt_q[alloc_slot] <= wr_tgt;
      alloc_slot <= alloc_slot + 1'b1;
    end
  end
endmodule

// File: rtl/osp_shared_pred.sv
module osp_shared_pred #(
  parameter int PC_W    = 14,
  parameter int GHR_W   = 8,
  parameter int BASE_AW = 6,
  parameter int TAG_AW  = 6,
  parameter int TGT_W   = 16,
  parameter int DOBS_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      lk_valid,
  input  logic [PC_W-1:0]           lk_pc,
  input  logic [1:0]                lk_kind,
  input  logic                      up_valid,
  input  logic [PC_W-1:0]           up_pc,
  input  logic [1:0]                up_kind,
  input  logic [GHR_W-1:0]          up_ghr,
  input  logic                      up_wrong,
  input  logic                      up_taken,
  input  logic [DOBS_W-1:0]         up_dist,
  input  logic [TGT_W-1:0]          up_target,
  output logic                      rsp_ack,
  output logic                      rsp_valid,
  output logic                      rsp_tagged,
  output logic                      rsp_taken,
  output logic [osp_pkg::FLD_W-1:0] rsp_dist,
  output logic [TGT_W-1:0]          rsp_target,
  output logic [GHR_W-1:0]          rsp_ghr
);
  import osp_pkg::*;
  localparam int TAG_W = PC_W - TAG_AW;
  localparam logic [DOBS_W-1:0] DIST_MAX = DOBS_W'((1 << FLD_W) - 1);

  logic [GHR_W-1:0] ghr_q;

  function automatic logic [TAG_AW-1:0] mk_idx(input logic [PC_W-1:0] pc, input logic [GHR_W-1:0] h);
    return pc[TAG_AW-1:0] ^ h[TAG_AW-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] mk_tag(input logic [PC_W-1:0] pc, input logic [GHR_W-1:0] h);
    return pc[PC_W-1:TAG_AW] ^ TAG_W'(h >> TAG_AW);
  endfunction

  // lookup side
  logic [TAG_AW-1:0] lk_idx, upd_idx;
  logic [TAG_W-1:0]  lk_tag, upd_tag;
  logic              rd_val, upd_val;
  logic [TAG_W-1:0]  rd_tag, upd_old_tag;
  logic [FLD_W-1:0]  rd_fld, upd_fld, base_ctr, tb_slot;
  logic [TGT_W-1:0]  tb_tgt;
  logic              lk_hit, upd_hit, pred_dir;

  // update side
  logic             wr_en, tb_wr, base_en, restore_en;
  logic [FLD_W-1:0] wr_fld;

  assign lk_idx   = mk_idx(lk_pc, ghr_q);
  assign lk_tag   = mk_tag(lk_pc, ghr_q);
  assign upd_idx  = mk_idx(up_pc, up_ghr);
  assign upd_tag  = mk_tag(up_pc, up_ghr);
  assign lk_hit   = rd_val && (rd_tag == lk_tag);
  assign upd_hit  = upd_val && (upd_old_tag == upd_tag);
  assign pred_dir = lk_hit ? rd_fld[FLD_W-1] : base_ctr[FLD_W-1];

  assign restore_en = up_valid && (kind_e'(up_kind) == KIND_COND) && up_wrong;

  osp_ghr #(.GHR_W(GHR_W)) ghr_i (
    .clk(clk), .rst(rst),
    .shift_en(lk_valid && (kind_e'(lk_kind) == KIND_COND)),
    .shift_bit(pred_dir),
    .restore_en(restore_en),
    .restore_val({up_ghr[GHR_W-2:0], up_taken}),
    .hist_q(ghr_q)
  );

  osp_base #(.AW(BASE_AW)) base_i (
    .clk(clk), .rst(rst),
    .rd_idx(lk_pc[BASE_AW-1:0]), .rd_ctr(base_ctr),
    .up_en(base_en), .up_idx(up_pc[BASE_AW-1:0]), .up_dir(up_taken)
  );

  osp_tagtab #(.AW(TAG_AW), .TAG_W(TAG_W)) tag_i (
    .clk(clk), .rst(rst),
    .rd_idx(lk_idx), .rd_val(rd_val), .rd_tag(rd_tag), .rd_fld(rd_fld),
    .up_idx(upd_idx), .up_val(upd_val), .up_tag(upd_old_tag), .up_fld(upd_fld),
    .wr_en(wr_en), .wr_tag(upd_tag), .wr_fld(wr_fld)
  );

  osp_tbuf #(.TGT_W(TGT_W)) tbuf_i (
    .clk(clk), .rst(rst),
    .rd_slot(rd_fld), .rd_tgt(tb_tgt),
    .wr_en(tb_wr), .wr_tgt(up_target), .alloc_slot(tb_slot)
  );

  // training decisions for one resolved instruction
  always_comb begin
    wr_en   = 1'b0;
    wr_fld  = '0;
    tb_wr   = 1'b0;
    base_en = 1'b0;
    if (up_valid) begin
      unique case (kind_e'(up_kind))
        KIND_COND: begin
          base_en = 1'b1;
          if (up_wrong) begin
            wr_en  = 1'b1;
            wr_fld = up_taken ? 3'd4 : 3'd3;
          end else if (upd_hit) begin
            wr_en  = 1'b1;
            wr_fld = sat_step(upd_fld, up_taken);
          end
        end
        KIND_LOAD: begin
          if (up_wrong) begin
            wr_en  = 1'b1;
            wr_fld = (up_dist > DIST_MAX) ? DIST_MAX[FLD_W-1:0] : up_dist[FLD_W-1:0];
          end
        end
        KIND_IND: begin
          if (up_wrong) begin
            wr_en  = 1'b1;
            tb_wr  = 1'b1;
            wr_fld = tb_slot;
          end
        end
        default: ;
      endcase
    end
  end

  // answer, registered
  logic             nx_valid, nx_tagged, nx_taken;
  logic [FLD_W-1:0] nx_dist;
  logic [TGT_W-1:0] nx_tgt;

  always_comb begin
    nx_valid  = 1'b0;
    nx_tagged = 1'b0;
    nx_taken  = 1'b0;
    nx_dist   = '0;
    nx_tgt    = '0;
    if (lk_valid) begin
      unique case (kind_e'(lk_kind))
        KIND_COND: begin
          nx_valid  = 1'b1;
          nx_tagged = lk_hit;
          nx_taken  = pred_dir;
        end
        KIND_LOAD: if (lk_hit) begin
          nx_valid  = 1'b1;
          nx_tagged = 1'b1;
          nx_dist   = rd_fld;
        end
        KIND_IND: if (lk_hit) begin
          nx_valid  = 1'b1;
          nx_tagged = 1'b1;
          nx_tgt    = tb_tgt;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_ack    <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_tagged <= 1'b0;
      rsp_taken  <= 1'b0;
      rsp_dist   <= '0;
      rsp_target <= '0;
      rsp_ghr    <= '0;
    end else begin
      rsp_ack    <= lk_valid;
      rsp_valid  <= nx_valid;
      rsp_tagged <= nx_tagged;
      rsp_taken  <= nx_taken;
      rsp_dist   <= nx_dist;
      rsp_target <= nx_tgt;
      rsp_ghr    <= lk_valid ? ghr_q : '0;
    end
  end
endmodule

// File: rtl/osp_shared_pred_chk.sv
module osp_shared_pred_chk #(
  parameter int GHR_W = 8,
  parameter int TGT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_valid,
  input logic [1:0]       lk_kind,
  input logic             up_valid,
  input logic [1:0]       up_kind,
  input logic             up_wrong,
  input logic             up_taken,
  input logic [GHR_W-1:0] up_ghr,
  input logic             rsp_ack,
  input logic             rsp_valid,
  input logic             rsp_tagged,
  input logic             rsp_taken,
  input logic [2:0]       rsp_dist,
  input logic [TGT_W-1:0] rsp_target,
  input logic [GHR_W-1:0] ghr_q
);
  // R1
  ack_follows_chk: assert property (@(posedge clk) disable iff (rst) lk_valid |=> rsp_ack);
  // R1
  no_stray_ack_chk: assert property (@(posedge clk) disable iff (rst) !lk_valid |=> !rsp_ack);
  // R2
  none_kind_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_kind == 2'b11) |=> (!rsp_valid && !rsp_tagged && !rsp_taken && rsp_dist == '0 && rsp_target == '0));
  // R4
  cond_always_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_kind == 2'b00) |=> rsp_valid);
  // R5
  load_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_kind == 2'b01) |=> (rsp_valid == rsp_tagged && !rsp_taken && rsp_target == '0));
  // R6
  ind_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_kind == 2'b10) |=> (rsp_valid == rsp_tagged && !rsp_taken && rsp_dist == '0));
  // R11
  hist_restore_chk: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_kind == 2'b00 && up_wrong) |=> ghr_q == {$past(up_ghr[GHR_W-2:0]), $past(up_taken)});
  // R10
  hist_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_kind == 2'b00 && !(up_valid && up_kind == 2'b00 && up_wrong))
      |=> ghr_q == {$past(ghr_q[GHR_W-2:0]), rsp_taken});
endmodule

bind osp_shared_pred osp_shared_pred_chk #(.GHR_W(GHR_W), .TGT_W(TGT_W)) chk_i (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_kind(lk_kind),
  .up_valid(up_valid), .up_kind(up_kind), .up_wrong(up_wrong), .up_taken(up_taken),
  .up_ghr(up_ghr), .rsp_ack(rsp_ack), .rsp_valid(rsp_valid), .rsp_tagged(rsp_tagged),
  .rsp_taken(rsp_taken), .rsp_dist(rsp_dist), .rsp_target(rsp_target), .ghr_q(ghr_q)
);

// File: tb/osp_shared_pred_tb_top.sv
module osp_shared_pred_tb_top;
  localparam int CLK_P  = 10;
  localparam int PC_W   = 14;
  localparam int GHR_W  = 8;
  localparam int AW     = 6;
  localparam int TGT_W  = 16;
  localparam int DOBS_W = 4;
  localparam int TAG_W  = PC_W - AW;
  localparam int DEPTH  = 1 << AW;

  logic clk, rst;
  logic lk_valid, up_valid, up_wrong, up_taken;
  logic [PC_W-1:0] lk_pc, up_pc;
  logic [1:0] lk_kind, up_kind;
  logic [GHR_W-1:0] up_ghr;
  logic [DOBS_W-1:0] up_dist;
  logic [TGT_W-1:0] up_target;
  logic rsp_ack, rsp_valid, rsp_tagged, rsp_taken;
  logic [2:0] rsp_dist;
  logic [TGT_W-1:0] rsp_target;
  logic [GHR_W-1:0] rsp_ghr;

  osp_shared_pred dut_i (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_kind(lk_kind),
    .up_valid(up_valid), .up_pc(up_pc), .up_kind(up_kind), .up_ghr(up_ghr),
    .up_wrong(up_wrong), .up_taken(up_taken), .up_dist(up_dist), .up_target(up_target),
    .rsp_ack(rsp_ack), .rsp_valid(rsp_valid), .rsp_tagged(rsp_tagged), .rsp_taken(rsp_taken),
    .rsp_dist(rsp_dist), .rsp_target(rsp_target), .rsp_ghr(rsp_ghr)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // reference state built from the requirements
  bit               m_val  [DEPTH];
  logic [TAG_W-1:0] m_tag  [DEPTH];
  logic [2:0]       m_fld  [DEPTH];
  logic [2:0]       m_base [DEPTH];
  logic [TGT_W-1:0] m_tb   [8];
  logic [2:0]       m_rr;
  logic [GHR_W-1:0] m_ghr;

  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic chk(input string why, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", why, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] f_idx(input logic [PC_W-1:0] pc, input logic [GHR_W-1:0] h);
    return pc[AW-1:0] ^ h[AW-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] f_tag(input logic [PC_W-1:0] pc, input logic [GHR_W-1:0] h);
    return pc[PC_W-1:AW] ^ TAG_W'(h >> AW);
  endfunction

  function automatic logic [2:0] f_sat(input logic [2:0] v, input logic up);
    if (up) return (v == 3'd7) ? v : v + 3'd1;
    return (v == 3'd0) ? v : v - 3'd1;
  endfunction

  task automatic cycle(input string note, input logic lv, input logic [PC_W-1:0] lpc, input logic [1:0] lk,
                       input logic uv, input logic [PC_W-1:0] upc, input logic [1:0] uk,
                       input logic [GHR_W-1:0] ughr, input logic uw, input logic ut,
                       input logic [DOBS_W-1:0] ud, input logic [TGT_W-1:0] utg);
    logic e_valid, e_tagd, e_taken, hit, uhit;
    logic [2:0] e_dist;
    logic [TGT_W-1:0] e_tgt;
    logic [GHR_W-1:0] e_ghr;
    logic [AW-1:0] li, ui;
    string rq;
    lk_valid = lv; lk_pc = lpc; lk_kind = lk;
    up_valid = uv; up_pc = upc; up_kind = uk; up_ghr = ughr;
    up_wrong = uw; up_taken = ut; up_dist = ud; up_target = utg;
    // R3 hashing, R12 answer from pre-edge state
    li = f_idx(lpc, m_ghr);
    hit = m_val[li] && (m_tag[li] == f_tag(lpc, m_ghr));
    e_valid = 0; e_tagd = 0; e_taken = 0; e_dist = 0; e_tgt = 0;
    e_ghr = lv ? m_ghr : '0;
    if (lv) begin
      case (lk)
        2'b00: begin e_valid = 1; e_tagd = hit; e_taken = hit ? m_fld[li][2] : m_base[lpc[AW-1:0]][2]; end
        2'b01: if (hit) begin e_valid = 1; e_tagd = 1; e_dist = m_fld[li]; end
        2'b10: if (hit) begin e_valid = 1; e_tagd = 1; e_tgt = m_tb[m_fld[li]]; end
        default: ;
      endcase
    end
    // R11 restore over R10 shift
    if (uv && uk == 2'b00 && uw) m_ghr = {ughr[GHR_W-2:0], ut};
    else if (lv && lk == 2'b00) m_ghr = {m_ghr[GHR_W-2:0], e_taken};
    if (uv) begin
      ui = f_idx(upc, ughr);
      uhit = m_val[ui] && (m_tag[ui] == f_tag(upc, ughr));
      case (uk)
        2'b00: begin // R7
          m_base[upc[AW-1:0]] = f_sat(m_base[upc[AW-1:0]], ut);
          if (uw) begin m_val[ui] = 1; m_tag[ui] = f_tag(upc, ughr); m_fld[ui] = ut ? 3'd4 : 3'd3; end
          else if (uhit) m_fld[ui] = f_sat(m_fld[ui], ut);
        end
        2'b01: if (uw) begin // R8
          m_val[ui] = 1; m_tag[ui] = f_tag(upc, ughr); m_fld[ui] = (ud > 7) ? 3'd7 : ud[2:0];
        end
        2'b10: if (uw) begin // R9
          m_tb[m_rr] = utg; m_val[ui] = 1; m_tag[ui] = f_tag(upc, ughr); m_fld[ui] = m_rr; m_rr = m_rr + 3'd1;
        end
        default: ;
      endcase
    end
    @(negedge clk);
    rq = (lk == 2'b00) ? "R4" : (lk == 2'b01) ? "R5" : (lk == 2'b10) ? "R6" : "R2";
    chk({"R1 ack ", note}, {31'd0, rsp_ack}, {31'd0, lv});
    if (lv) begin
      chk({rq, " valid ", note}, {31'd0, rsp_valid}, {31'd0, e_valid});
      chk({rq, " tagged ", note}, {31'd0, rsp_tagged}, {31'd0, e_tagd});
      chk({rq, " taken ", note}, {31'd0, rsp_taken}, {31'd0, e_taken});
      chk({rq, " dist ", note}, {29'd0, rsp_dist}, {29'd0, e_dist});
      chk({rq, " target ", note}, {16'd0, rsp_target}, {16'd0, e_tgt});
      chk({"R10 ghr ", note}, {24'd0, rsp_ghr}, {24'd0, e_ghr});
    end
  endtask

  task automatic look(input string note, input logic [PC_W-1:0] pc, input logic [1:0] k);
    cycle(note, 1, pc, k, 0, '0, 2'b11, '0, 0, 0, '0, '0);
  endtask

  task automatic upd(input string note, input logic [PC_W-1:0] pc, input logic [1:0] k, input logic [GHR_W-1:0] h,
                     input logic w, input logic t, input logic [DOBS_W-1:0] d, input logic [TGT_W-1:0] tg);
    cycle(note, 0, '0, 2'b11, 1, pc, k, h, w, t, d, tg);
  endtask

  logic [PC_W-1:0] pool [6];

  initial begin
    void'($urandom(32'd4242));
    pool[0] = 14'h0010; pool[1] = 14'h1234; pool[2] = 14'h2200;
    pool[3] = 14'h0340; pool[4] = 14'h3ff5; pool[5] = 14'h0005;
    for (int i = 0; i < DEPTH; i++) begin m_val[i] = 0; m_tag[i] = '0; m_fld[i] = '0; m_base[i] = 3'd3; end
    for (int i = 0; i < 8; i++) m_tb[i] = '0;
    m_rr = '0; m_ghr = '0;
    rst = 1; lk_valid = 0; lk_pc = '0; lk_kind = 2'b11; up_valid = 0; up_pc = '0; up_kind = 2'b11;
    up_ghr = '0; up_wrong = 0; up_taken = 0; up_dist = '0; up_target = '0;
    repeat (4) @(negedge clk);
    chk("R1 reset ack", {31'd0, rsp_ack}, 32'd0);
    chk("R1 reset valid", {31'd0, rsp_valid}, 32'd0);
    rst = 0;
    look("base reset value 3 gives not taken", 14'h0010, 2'b00);
    look("kind none", 14'h0010, 2'b11);
    look("load miss", 14'h1234, 2'b01);
    upd("R8 violation dist 9", 14'h1234, 2'b01, m_ghr, 1, 0, 4'd9, '0);
    look("R8 clamped to 7", 14'h1234, 2'b01);
    chk("R8 dist value", {29'd0, rsp_dist}, 32'd7);
    upd("R9 indirect alloc", 14'h2200, 2'b10, m_ghr, 1, 0, '0, 16'hBEEF);
    look("R9 indirect hit", 14'h2200, 2'b10);
    chk("R9 target value", {16'd0, rsp_target}, 32'h0000BEEF);
    upd("R11 restore ff", 14'h0340, 2'b00, 8'hFF, 1, 1, '0, '0);
    look("R7 tagged taken after restore", 14'h0340, 2'b00);
    chk("R11 restored history", {24'd0, rsp_ghr}, 32'h000000FF);
    chk("R7 taken value", {31'd0, rsp_taken}, 32'd1);
    chk("R3 tagged hit", {31'd0, rsp_tagged}, 32'd1);
    cycle("R12 same-cycle update", 1, 14'h1234, 2'b01, 1, 14'h1234, 2'b01, m_ghr, 1, 0, 4'd2, '0);
    look("R12 update seen next", 14'h1234, 2'b01);
    chk("R12 new dist", {29'd0, rsp_dist}, 32'd2);
    for (int i = 0; i < 9; i++) upd("R7 base train", 14'h0005, 2'b00, 8'h00, 0, 1, '0, '0);
    look("R7 base saturated", 14'h0005, 2'b00);
    for (int i = 0; i < 4000; i++) begin
      logic [GHR_W-1:0] h;
      h = ($urandom % 10 < 7) ? m_ghr : GHR_W'($urandom);
      cycle("random", ($urandom % 4) != 0, pool[$urandom % 6], 2'($urandom),
            ($urandom % 3) != 0, pool[$urandom % 6], 2'($urandom), h,
            ($urandom % 2) == 0, 1'($urandom), 4'($urandom), 16'($urandom));
    end
    lk_valid = 0; up_valid = 0;
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      bad++;
      $display("FAIL R1 watchdog expired act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule